// File: doc/BRIEF.md
# Half-Word Instruction Issue Sequencer

This block sits between instruction fetch and instruction decode. Every fetched word holds either one full-width instruction or two half-width instructions packed together, and a flag that comes with the word tells which. A full word goes to the decoder as a single transfer. A packed word goes as two transfers: the upper half first, then the lower half. A lower half that is all zeros marks an unused slot, and the block skips it.

Both data interfaces use valid/ready. On the fetch side, `in_ready` is the request for the next word. It is high only when the held word has been used up: either nothing is held, or the last piece of the held word is handed over in this very cycle. When that happens, a new word moves in with no bubble. `in_ready` therefore depends combinationally on `out_ready`. On the decode side, a piece stays on `out_data`/`out_half` with `out_valid` high until `out_ready` takes it. `flush` is a plain control pin. In the cycle it is high, it blocks both handshakes, and it leaves the block empty in the next cycle.

Top module: `hw_issue_seq`

## Requirements
- R1: After reset, `out_valid` is 0 and `in_ready` is 1.
- R2: A word accepted with `in_packed`=0 is issued as one transfer, with `out_data` equal to the whole word and `out_half`=0.
- R3: A word accepted with `in_packed`=1 first issues its upper half (bits WORD_W-1:WORD_W/2). It is placed in bits WORD_W/2-1:0 of `out_data`, the upper bits are zero, and `out_half`=1.
- R4: After the upper half has been taken, a non-zero lower half (bits WORD_W/2-1:0) is issued next, zero-extended the same way and with `out_half`=1.
- R5: A lower half that is all zeros is never issued. The next transfer after the upper half comes from the next fetched word.
- R6: While `out_valid`=1 and `out_ready`=0, the next cycle shows the same `out_data` and `out_half`.
- R7: `in_ready` is 1 exactly when `flush`=0 and either no piece is pending or the last pending piece of the held word is taken in the same cycle.
- R8: While `flush`=1, `out_valid` and `in_ready` are 0. In the cycle after, `out_valid` is 0, `in_ready` is 1, and any pending half is lost.
- R9: When the last piece is taken in the same cycle a new word is accepted, the new word's first piece is valid in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| flush | input | 1 | Discard the held word and go empty |
| in_valid | input | 1 | Fetched word is present |
| in_ready | output | 1 | Request/accept for the next fetched word |
| in_word | input | WORD_W | Fetched word |
| in_packed | input | 1 | Word carries two half-width instructions |
| out_valid | output | 1 | An instruction piece is offered |
| out_ready | input | 1 | Decoder takes the offered piece |
| out_data | output | WORD_W | Full word, or half zero-extended in the low bits |
| out_half | output | 1 | Offered piece is half width |

## Verification
A wrong phase in the sequencer shows at the decode port within one handshake. The decoder would see a lower half issued twice, a half issued first from the lower bits, a zero lower half issued as an instruction, or the next word issued while a half is still owed. Each of these makes the stream of transfers differ from the stream expected from the accepted words at the first transfer after the fault. A wrong "used up" decision shows in the same cycle as a wrong level on `in_ready`. A flush that leaves state behind shows one cycle later as a stale `out_valid`.

// File: rtl/hw_seq_pkg.sv
package hw_seq_pkg;
  typedef enum logic [1:0] {
    SLOT_EMPTY = 2'd0,
    SLOT_FULL  = 2'd1,
    SLOT_UPPER = 2'd2,
    SLOT_LOWER = 2'd3
  } slot_e;
endpackage

// File: rtl/hw_word_hold.sv
module hw_word_hold #(
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [WORD_W-1:0] d_word,
  output logic [WORD_W-1:0] q_word,
  output logic              q_lower_zero
);
  localparam int HALF_W = WORD_W / 2;

  // The zero test on the lower half is done once, at load time.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_word       <= '0;
      q_lower_zero <= 1'b1;
    end else if (load) begin
      q_word       <= d_word;
      q_lower_zero <= (d_word[HALF_W-1:0] == '0);
    end
  end
endmodule

// File: rtl/hw_seq_ctrl.sv
module hw_seq_ctrl
  import hw_seq_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  flush,
  input  logic  load,
  input  logic  load_packed,
  input  logic  lower_zero,
  input  logic  fire,
  output slot_e slot,
  output logic  last_piece
);
  slot_e slot_nxt;

  assign last_piece = (slot == SLOT_FULL) || (slot == SLOT_LOWER) ||
                      ((slot == SLOT_UPPER) && lower_zero);

  always_comb begin
    slot_nxt = slot;
    if (fire) begin
      unique case (slot)
        SLOT_UPPER: slot_nxt = lower_zero ? SLOT_EMPTY : SLOT_LOWER;
        SLOT_FULL,
        SLOT_LOWER: slot_nxt = SLOT_EMPTY;
        default:    slot_nxt = slot;
      endcase
    end
    if (load)  slot_nxt = load_packed ? SLOT_UPPER : SLOT_FULL;
    if (flush) slot_nxt = SLOT_EMPTY;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) slot <= SLOT_EMPTY;
    else        slot <= slot_nxt;
  end

  // R5: an empty lower slot is never entered
  p_zero_lower_skip_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (slot == SLOT_UPPER && fire && lower_zero && !load) |=> (slot == SLOT_EMPTY));

  // R4: a live lower half follows its upper half
  p_lower_follows_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (slot == SLOT_UPPER && fire && !lower_zero && !flush) |=> (slot == SLOT_LOWER));

  // R8: flush leaves nothing pending
  p_flush_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (slot == SLOT_EMPTY));
endmodule

// File: rtl/hw_issue_mux.sv
module hw_issue_mux
  import hw_seq_pkg::*;
#(
  parameter int WORD_W = 32
) (
  input  slot_e             slot,
  input  logic [WORD_W-1:0] word,
  output logic [WORD_W-1:0] data,
  output logic              half
);
  localparam int HALF_W = WORD_W / 2;

  logic [HALF_W-1:0] pick;

  assign half = (slot == SLOT_UPPER) || (slot == SLOT_LOWER);
  assign pick = (slot == SLOT_UPPER) ? word[WORD_W-1:HALF_W] : word[HALF_W-1:0];

  generate
    for (genvar b = 0; b < WORD_W; b++) begin : g_bit
      if (b < HALF_W) begin : g_lo
        assign data[b] = half ? pick[b] : word[b];
      end else begin : g_hi
        assign data[b] = half ? 1'b0 : word[b];
      end
    end
  endgenerate
endmodule

// File: rtl/hw_issue_seq.sv
module hw_issue_seq
  import hw_seq_pkg::*;
#(
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [WORD_W-1:0] in_word,
  input  logic              in_packed,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [WORD_W-1:0] out_data,
  output logic              out_half
);
  localparam int HALF_W = WORD_W / 2;

  slot_e             slot;
  logic              last_piece;
  logic              fire;
  logic              load;
  logic [WORD_W-1:0] held_word;
  logic              lower_zero;

  assign out_valid = (slot != SLOT_EMPTY) && !flush;
  assign fire      = out_valid && out_ready;
  assign in_ready  = !flush && ((slot == SLOT_EMPTY) || (fire && last_piece));
  assign load      = in_valid && in_ready;

  hw_word_hold #(.WORD_W(WORD_W)) u_hold (
    .clk          (clk),
    .rst_n        (rst_n),
    .load         (load),
    .d_word       (in_word),
    .q_word       (held_word),
    .q_lower_zero (lower_zero)
  );

  hw_seq_ctrl u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .flush       (flush),
    .load        (load),
    .load_packed (in_packed),
    .lower_zero  (lower_zero),
    .fire        (fire),
    .slot        (slot),
    .last_piece  (last_piece)
  );

  hw_issue_mux #(.WORD_W(WORD_W)) u_mux (
    .slot (slot),
    .word (held_word),
    .data (out_data),
    .half (out_half)
  );

  // R6: an offered piece does not change under back-pressure
  p_hold_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> ($stable(out_data) && $stable(out_half)));

  // R3: half pieces carry zeros in the upper bits
  p_half_zext_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_half) |-> (out_data[WORD_W-1:HALF_W] == '0));

  // R7: a new word is accepted only when the offered piece is not stalled
  p_in_ready_r7: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> (!out_valid || out_ready));

  // R8: nothing offered in the cycle after a flush
  p_flush_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !out_valid);

  // R9: accepting a word always yields an offered piece next cycle
  p_no_bubble_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !flush) |=> (out_valid || flush));
endmodule

// File: tb/hw_issue_seq_bench.sv
module hw_issue_seq_bench;
  localparam int W = 32;
  localparam int H = W / 2;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         flush = 1'b0;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [W-1:0] in_word = '0;
  logic         in_packed = 1'b0;
  logic         out_valid;
  logic         out_ready = 1'b0;
  logic [W-1:0] out_data;
  logic         out_half;

  int n_checks = 0;
  int n_fail   = 0;

  logic [W:0] exp_q[$];   // {half, data}
  string      tag_q[$];
  logic [W:0] stall_val;
  logic       stall_seen = 1'b0;

  always #5 clk = ~clk;

  hw_issue_seq #(.WORD_W(W)) u_hw_issue_seq (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .in_valid(in_valid), .in_ready(in_ready), .in_word(in_word), .in_packed(in_packed),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .out_half(out_half)
  );

  task automatic check(input string req, input logic [W:0] act, input logic [W:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [W:0] zext_half(input logic [H-1:0] h);
    return {1'b1, {H{1'b0}}, h};
  endfunction

  // Push the pieces the requirements say a word must produce.
  task automatic model_accept(input logic [W-1:0] w, input logic pk);
    if (!pk) begin
      exp_q.push_back({1'b0, w}); tag_q.push_back("R2");
    end else begin
      exp_q.push_back(zext_half(w[W-1:H]));
      tag_q.push_back(w[H-1:0] == '0 ? "R5" : "R3");
      if (w[H-1:0] != '0) begin
        exp_q.push_back(zext_half(w[H-1:0])); tag_q.push_back("R4");
      end
    end
  endtask

  task automatic cycle(input logic iv, input logic [W-1:0] w, input logic pk,
                       input logic ordy, input logic fl);
    logic exp_rdy, exp_vld, acc;
    @(negedge clk);
    in_valid = iv; in_word = w; in_packed = pk; out_ready = ordy; flush = fl;
    #4;
    if (stall_seen) check("R6", {out_half, out_data}, stall_val);
    exp_vld = !fl && (exp_q.size() > 0);
    exp_rdy = !fl && (exp_q.size() == 0 || (exp_q.size() == 1 && ordy));
    check(fl ? "R8" : "R7", {in_ready, out_valid}, {exp_rdy, exp_vld});
    stall_seen = out_valid && !ordy;
    stall_val  = {out_half, out_data};
    if (out_valid && ordy && exp_q.size() > 0) begin
      check(tag_q[0], {out_half, out_data}, exp_q[0]);
      void'(exp_q.pop_front()); void'(tag_q.pop_front());
    end
    acc = iv && in_ready;
    if (fl) begin
      exp_q.delete(); tag_q.delete();
    end
    if (acc) model_accept(w, pk);
  endtask

  initial begin : watchdog
    #2_000_000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin : main
    int unsigned seed;
    seed = 32'd20240611;
    void'($urandom(seed));
    #12;
    check("R1", {in_ready, out_valid}, {1'b1, 1'b0});
    rst_n = 1'b1;
    // R2 full word
    cycle(1, 32'hDEAD_BEEF, 0, 1, 0);
    cycle(0, '0, 0, 1, 0);
    // R3/R4 packed with back-pressure (R6)
    cycle(1, 32'h1234_5678, 1, 0, 0);
    cycle(0, '0, 0, 0, 0);
    cycle(0, '0, 0, 0, 0);
    cycle(0, '0, 0, 1, 0);
    cycle(0, '0, 0, 1, 0);
    // R5 zero lower, then R9 back-to-back
    cycle(1, 32'hABCD_0000, 1, 1, 0);
    cycle(1, 32'h0F0F_F0F0, 0, 1, 0);
    cycle(1, 32'h1111_2222, 1, 1, 0);
    // R8 flush while lower half owed
    cycle(0, '0, 0, 1, 0);
    cycle(1, 32'h5555_6666, 0, 1, 1);
    cycle(0, '0, 0, 1, 0);
    cycle(1, 32'h7777_8888, 0, 1, 0);
    cycle(0, '0, 0, 1, 0);
    // constrained random
    for (int i = 0; i < 4000; i++) begin
      logic [W-1:0] w;
      logic pk;
      w  = $urandom;
      pk = $urandom_range(0, 1);
      if (pk && $urandom_range(0, 3) == 0) w[H-1:0] = '0;
      cycle($urandom_range(0, 3) != 0, w, pk, $urandom_range(0, 3) != 0,
            $urandom_range(0, 40) == 0);
    end
    for (int i = 0; i < 4; i++) cycle(0, '0, 0, 1, 0);
    check("R7", {31'd0, exp_q.size() == 0}, 32'd1);
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule